// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Controller

This block is a direct-mapped cache that reaches roughly the hit rate of a two-way cache. Each lookup first tries the line chosen by the low address bits, which is the primary line. If that line does not hold the block, the controller tries one more line: the one whose index differs only in its most significant bit. A match on the first try is a fast hit. A match on the second try is a slow hit. After a slow hit the two lines trade places, so the block that was just used sits at its primary line from then on.

When neither line holds the block, the controller asks the next memory level for it. The returned word is written into the primary line, and the block that was there moves into the partner line. Whatever the partner line held before is overwritten. Each stored key holds the upper address bits together with the top index bit. This lets both lines be compared against the same requested address.

The processor side offers a request with `ready` and gets one `resp_valid` pulse per accepted request. The refill side raises `fill_req` and waits for `fill_valid`. Three counters report how many requests ended as a fast hit, a slow hit or a miss.

Top module: `pseudo_assoc_lookup`

## Requirements
- R1: After reset `ready` is 1, `resp_valid` and `fill_req` are 0, all three counters are 0 and every line is invalid, so the first access to any address is a miss.
- R2: A request accepted (`req_valid` and `ready` at a rising edge) whose block is valid at its primary line `addr[IW-1:0]` produces `resp_valid` with that block's data at the next edge, and `cnt_fast` rises by 1.
- R3: If the primary line misses, the line at index `addr[IW-1:0]` with bit IW-1 inverted is checked. A match there gives `resp_valid` with the data two edges after acceptance, and `cnt_slow` rises by 1.
- R4: After a slow hit, `ready` is 0 for exactly the swap cycle, during which the two lines exchange contents. An immediate repeat of the same address is then a fast hit.
- R5: If both lines miss, `fill_req` rises with `fill_addr` equal to the request address and stays high with a stable address until `fill_valid`. `resp_valid` follows at the next edge carrying `fill_data`, and `cnt_miss` rises by 1.
- R6: On a refill the new block takes the primary line, and the previous primary block moves to the partner line, replacing the partner's old content. A later access to the displaced block is a slow hit, and the partner's old block misses.
- R7: Every response raises exactly one of `cnt_fast`, `cnt_slow` and `cnt_miss` by one. No counter changes without a response.
- R8: A line matches only if its stored key equals `addr[AW-1:IW-1]`, which includes the top index bit. An address never hits on the block of its top-bit-flipped neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_addr | input | AW | Word address of the request |
| ready | output | 1 | Controller can accept a request |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_data | output | DW | Data returned for the request |
| fill_req | output | 1 | Refill request to next level |
| fill_addr | output | AW | Address being refilled |
| fill_valid | input | 1 | Refill data present |
| fill_data | input | DW | Refill data |
| cnt_fast | output | CW | Count of fast hits |
| cnt_slow | output | CW | Count of slow hits |
| cnt_miss | output | CW | Count of misses |

## Verification
A small configuration with eight lines and 64 addresses is used. A sequential sweep of every address checks cold misses and the key comparison between top-bit neighbours. An immediate repeat of the sweep then separates fast hits from slow hits created by displacement. A per-index conflict pattern alternates two addresses that share a primary line, which forces the miss, displacement, slow hit and swap sequence. A long pseudo-random address stream is compared against a behavioural two-line model kept in the bench, and each response's class, latency and data are checked against that model.

// File: rtl/pseudo_assoc_lookup.sv
module pseudo_assoc_lookup #(
  parameter int AW = 12,
  parameter int IW = 6,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          fill_req,
  output logic [AW-1:0] fill_addr,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  output logic [CW-1:0] cnt_fast,
  output logic [CW-1:0] cnt_slow,
  output logic [CW-1:0] cnt_miss
);
  localparam int LINES = 1 << IW;
  localparam int KW = AW - IW + 1;
  localparam logic [IW-1:0] FLIP = IW'(1) << (IW - 1);

  typedef enum logic [1:0] {S_IDLE, S_ALT, S_SWAP, S_FILL} state_t;
  state_t state;

  logic [LINES-1:0] v_q;
  logic [KW-1:0]    k_q [LINES];
  logic [DW-1:0]    d_q [LINES];
  logic [AW-1:0]    addr_q;

  wire [IW-1:0] in_idx = req_addr[IW-1:0];
  wire [IW-1:0] p_idx  = addr_q[IW-1:0];
  wire [IW-1:0] a_idx  = p_idx ^ FLIP;
  wire [KW-1:0] key_q  = addr_q[AW-1:IW-1];
  wire accept = req_valid && ready;
  wire fast   = v_q[in_idx] && (k_q[in_idx] == req_addr[AW-1:IW-1]);
  wire slow   = v_q[a_idx] && (k_q[a_idx] == key_q);
  wire filled = (state == S_FILL) && fill_valid;

  assign ready     = (state == S_IDLE);
  assign fill_req  = (state == S_FILL);
  assign fill_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      resp_valid <= 1'b0;
      v_q        <= '0;
      cnt_fast   <= '0;
      cnt_slow   <= '0;
      cnt_miss   <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (fast) begin
            resp_valid <= 1'b1;
            cnt_fast   <= cnt_fast + 1'b1;
          end else begin
            state <= S_ALT;
          end
        end
        S_ALT: if (slow) begin
          resp_valid <= 1'b1;
          cnt_slow   <= cnt_slow + 1'b1;
          state      <= S_SWAP;
        end else begin
          state <= S_FILL;
        end
        S_SWAP: begin
          v_q[p_idx] <= v_q[a_idx];
          v_q[a_idx] <= v_q[p_idx];
          state      <= S_IDLE;
        end
        default: if (fill_valid) begin
          v_q[p_idx] <= 1'b1;
          v_q[a_idx] <= v_q[p_idx];
          resp_valid <= 1'b1;
          cnt_miss   <= cnt_miss + 1'b1;
          state      <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) addr_q <= req_addr;
    if (accept && fast) resp_data <= d_q[in_idx];
    if (state == S_ALT && slow) resp_data <= d_q[a_idx];
    if (state == S_SWAP) begin
      k_q[p_idx] <= k_q[a_idx];
      k_q[a_idx] <= k_q[p_idx];
      d_q[p_idx] <= d_q[a_idx];
      d_q[a_idx] <= d_q[p_idx];
    end
    if (filled) begin
      k_q[p_idx] <= key_q;
      d_q[p_idx] <= fill_data;
      k_q[a_idx] <= k_q[p_idx];
      d_q[a_idx] <= d_q[p_idx];
      resp_data  <= fill_data;
    end
  end

  wire [CW-1:0] total = cnt_fast + cnt_slow + cnt_miss;

  assert_fast_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fast |=> resp_valid && ready);

  assert_slow_then_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ALT) && slow |=> resp_valid && !ready);

  assert_swap_primary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SWAP |=> ready && v_q[p_idx] && (k_q[p_idx] == key_q));

  assert_fill_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_valid |=> fill_req && $stable(fill_addr));

  assert_fill_primary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> v_q[p_idx] && (k_q[p_idx] == key_q) && (d_q[p_idx] == $past(fill_data)));

  assert_one_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> total == $past(total) + 1'b1);

  assert_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> $stable(total));
endmodule

// File: tb/tb_pseudo_assoc_lookup.sv
module tb_pseudo_assoc_lookup;
  localparam int AW = 6, IW = 3, DW = 8, CW = 16;
  localparam int LINES = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic ready, resp_valid, fill_req;
  logic [DW-1:0] resp_data;
  logic [AW-1:0] fill_addr;
  logic [CW-1:0] cnt_fast, cnt_slow, cnt_miss;

  int checks = 0, fails = 0;
  logic [AW-1:0] cur_addr = '0;
  logic          mv [LINES];
  logic [3:0]    mk [LINES];

  always #5 clk = ~clk;

  pseudo_assoc_lookup #(.AW(AW), .IW(IW), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .ready(ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
    .fill_data(fill_data), .cnt_fast(cnt_fast), .cnt_slow(cnt_slow),
    .cnt_miss(cnt_miss));

  function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
    return DW'(a * 5 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (fill_req && !fill_valid) begin
        check(fill_addr == cur_addr, "R5 fill_addr", fill_addr, cur_addr);
        repeat (2) @(negedge clk);
        check(fill_req == 1'b1 && fill_addr == cur_addr, "R5 fill held", fill_addr, cur_addr);
        fill_valid = 1'b1;
        fill_data  = mem(fill_addr);
        @(negedge clk);
        fill_valid = 1'b0;
      end
    end
  end

  task automatic access(input logic [AW-1:0] a);
    int lat;
    int cls;
    logic [CW-1:0] f0, s0, m0;
    logic [IW-1:0] p, q;
    logic [3:0] key;
    p = a[IW-1:0];
    q = p ^ 3'b100;
    key = a[AW-1:IW-1];
    if (mv[p] && mk[p] == key) cls = 0;
    else if (mv[q] && mk[q] == key) cls = 1;
    else cls = 2;
    @(negedge clk);
    while (!ready) @(negedge clk);
    f0 = cnt_fast; s0 = cnt_slow; m0 = cnt_miss;
    cur_addr = a;
    req_valid = 1'b1;
    req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid) begin
      @(negedge clk);
      lat++;
    end
    check(resp_data == mem(a), "R2/R3/R5 data", resp_data, mem(a));
    case (cls)
      0: begin
        check(lat == 1, "R2 fast latency", lat, 1);
        check(cnt_fast == f0 + 1 && cnt_slow == s0 && cnt_miss == m0, "R2 R7 fast count", cnt_fast, f0 + 1);
      end
      1: begin
        check(lat == 2, "R3 slow latency", lat, 2);
        check(cnt_slow == s0 + 1 && cnt_fast == f0 && cnt_miss == m0, "R3 R7 slow count", cnt_slow, s0 + 1);
        check(ready == 1'b0, "R4 swap cycle ready low", ready, 0);
        @(negedge clk);
        check(ready == 1'b1, "R4 ready after swap", ready, 1);
        mv[q] = mv[p]; mk[q] = mk[p];
        mv[p] = 1'b1;  mk[p] = key;
      end
      default: begin
        check(lat > 2, "R5 R6 R8 miss latency", lat, 5);
        check(cnt_miss == m0 + 1 && cnt_fast == f0 && cnt_slow == s0, "R5 R7 miss count", cnt_miss, m0 + 1);
        mv[q] = mv[p]; mk[q] = mk[p];
        mv[p] = 1'b1;  mk[p] = key;
      end
    endcase
  endtask

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; mk[i] = '0; end
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && resp_valid == 1'b0 && fill_req == 1'b0, "R1 reset outputs", ready, 1);
    check(cnt_fast == 0 && cnt_slow == 0 && cnt_miss == 0, "R1 reset counters", cnt_fast + cnt_slow + cnt_miss, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 64; a++) access(AW'(a));
    for (int a = 0; a < 64; a++) access(AW'(a));
    for (int i = 0; i < LINES; i++) begin
      access(AW'(i));
      access(AW'(i + 8));
      access(AW'(i));
      access(AW'(i));
      access(AW'(i + 8));
      access(AW'(i + 16));
      access(AW'(i ^ 4));
    end
    lfsr = 8'hA5;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      access(AW'(lfsr[5:0] & 6'h1D));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule